// File: doc/BRIEF.md
# Cascaded Converter Readout Controller

This block is the host-side master for a chain of serial sampling converters that share one read/convert line and one data clock supplied by the host. Each converter's serial output feeds the tag input of the next one, and the first converter's tag input is tied low. The host therefore sees, on a single data line, one 16-bit word per converter with a single zero bit between words. The word of the converter nearest the host comes first, and each word is sent MSB first.

On a start request the controller drives read/convert low for a fixed number of cycles to begin a conversion. It then waits for BUSY to fall and rise again. Once BUSY is high, the converters are in their sampling period, and the controller sends one gated burst of `N_DEV*17` data-clock pulses. It samples each bit on a falling edge, checks every separator bit and hands out each 16-bit result with its position in the chain. A done pulse closes the frame. If BUSY does not complete its low-then-high cycle within a bounded time, the controller flags a timeout, sends no clock and signals done.

Top module: `chain_readout`

## Requirements
- R1: While reset is held and in the first cycle after it, `rc_o` is 1, and `dclk_o`, `word_valid_o`, `done_o`, `frame_err_o` and `timeout_err_o` are 0.
- R2: A start request taken while idle drives `rc_o` low for exactly `CONV_CYC` consecutive cycles, and there is exactly one such low pulse per accepted start.
- R3: `dclk_o` is low whenever `rc_o` is low or `busy_i` is low, so the data clock never runs during a conversion. The first rising edge comes at least `HALF_CYC` cycles after BUSY is seen high.
- R4: A normal frame produces exactly `N_DEV*17` data-clock pulses. Every high phase lasts `HALF_CYC` cycles, and every low phase between pulses lasts `HALF_CYC` cycles (3 cycles = 24 ns at 125 MHz, for a period of at least 35 ns).
- R5: Serial bits are taken on falling edges of `dclk_o`. Bits 1..16 of each 17-bit slot form one word, MSB first. Word k is reported with `word_idx_o = k` in a one-cycle `word_valid_o` pulse, with word 0 (the nearest converter) first.
- R6: The 17th bit of each slot must be 0. If any separator is 1, `frame_err_o` rises and stays high until the next accepted start, and the words are still reported.
- R7: If BUSY has not gone low and then high within `TIMEOUT_CYC` cycles of the start, `timeout_err_o` is set, no data-clock pulse is sent and the frame ends with done. The flag clears on the next accepted start.
- R8: `done_o` is a single-cycle pulse, one per accepted start, after the last falling edge of the burst or after a timeout.
- R9: A start request while a frame is in progress has no effect: that frame keeps its pulse count, and no further conversion pulse follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one convert-and-read frame |
| busy_i | input | 1 | Shared BUSY from the converters (low while converting) |
| sdata_i | input | 1 | Serial data from the converter nearest the host |
| rc_o | output | 1 | Read/convert, low pulse starts a conversion |
| dclk_o | output | 1 | Gated data clock to all converters |
| word_valid_o | output | 1 | One-cycle strobe for a received word |
| word_o | output | 16 | Received 16-bit result |
| word_idx_o | output | IDX_W | Chain position of the word, 0 = nearest converter |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| frame_err_o | output | 1 | A separator bit was 1 in the current frame |
| timeout_err_o | output | 1 | BUSY did not complete its cycle in time |

## Verification
The main function is driven with several word pairs: mixed values, all-ones against all-zeros, and single set bits at the MSB and LSB. Together they show the bit order within a word, the word order across the chain, and whether a bit leaks across a slot boundary. A frame with a bad separator shows that the flag is sticky and that word delivery continues regardless. The clean frame after it shows that the flag clears on the next start. Two stalled BUSY patterns, one never falling and one never returning, separate the two wait states of the timeout path. A start pulse in the middle of a burst shows that requests are ignored while a frame runs.

// File: rtl/chain_readout_pkg.sv
// Shared types for the cascaded converter readout controller.
package chain_readout_pkg;
    // Frame sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WLOW,
        ST_WHIGH,
        ST_READ,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/rd_sequencer.sv
// Frame sequencer: issues the convert pulse, follows BUSY low then high,
// runs the read burst and closes the frame with done.
// Assumes TIMEOUT_CYC > CONV_CYC >= 1.
module rd_sequencer
    import chain_readout_pkg::*;
#(
    parameter int CONV_CYC    = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      busy_i,
    input  logic      burst_end_i,
    output rd_state_t state_o,
    output logic      start_ok_o,
    output logic      timeout_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] tcnt;
    logic          waiting;

    assign start_ok_o = (state_o == ST_IDLE) && start_i;
    assign waiting    = (state_o == ST_CONV) || (state_o == ST_WLOW) ||
                        (state_o == ST_WHIGH);

    // State progression with a single timer counting from the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o   <= ST_IDLE;
            tcnt      <= '0;
            timeout_o <= 1'b0;
        end else if (start_ok_o) begin
            state_o   <= ST_CONV;
            tcnt      <= '0;
            timeout_o <= 1'b0;
        end else if (waiting) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
                timeout_o <= 1'b1;
                state_o   <= ST_DONE;
            end else if (state_o == ST_CONV) begin
                if (tcnt == TW'(CONV_CYC - 1)) state_o <= ST_WLOW;
            end else if (state_o == ST_WLOW) begin
                if (!busy_i) state_o <= ST_WHIGH;
            end else begin
                if (busy_i) state_o <= ST_READ;
            end
        end else if (state_o == ST_READ) begin
            if (burst_end_i) state_o <= ST_DONE;
        end else if (state_o == ST_DONE) begin
            state_o <= ST_IDLE;
        end
    end
endmodule

// File: rtl/rd_clkgen.sv
// Gated data-clock generator: while enabled, toggles every HALF_CYC cycles
// starting low, and flags each falling edge and the last one of the burst.
module rd_clkgen #(
    parameter int HALF_CYC = 3,
    parameter int PULSES   = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic dclk_o,
    output logic fall_o,
    output logic last_o
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int PW = $clog2(PULSES + 1);

    logic [HW-1:0] hcnt;
    logic [PW-1:0] pcnt;
    logic          turn;

    assign turn   = en_i && (hcnt == HW'(HALF_CYC - 1));
    assign fall_o = turn && dclk_o;
    assign last_o = fall_o && (pcnt == PW'(PULSES - 1));

    // Half-period timer, clock level and pulse counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            hcnt   <= '0;
            pcnt   <= '0;
            dclk_o <= 1'b0;
        end else if (turn) begin
            hcnt   <= '0;
            dclk_o <= !dclk_o;
            if (dclk_o) pcnt <= pcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rd_deframer.sv
// Deframer: collects WORD_W bits per slot MSB first on falling-edge strobes,
// emits each word with its chain index, and checks the separator bit.
module rd_deframer #(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              fall_i,
    input  logic              sdata_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic              frame_err_o
);
    localparam int BW = $clog2(WORD_W + 1);

    logic [BW-1:0]     bitpos;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  widx;

    // Slot position, shift register, word output and separator check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitpos       <= '0;
            shreg        <= '0;
            widx         <= '0;
            word_valid_o <= 1'b0;
            word_o       <= '0;
            word_idx_o   <= '0;
            frame_err_o  <= 1'b0;
        end else begin
            word_valid_o <= 1'b0;
            if (clear_i) begin
                bitpos      <= '0;
                widx        <= '0;
                frame_err_o <= 1'b0;
            end else if (fall_i) begin
                if (bitpos == BW'(WORD_W)) begin
                    if (sdata_i) frame_err_o <= 1'b1;
                    bitpos <= '0;
                    widx   <= widx + 1'b1;
                end else begin
                    shreg  <= {shreg[WORD_W-2:0], sdata_i};
                    bitpos <= bitpos + 1'b1;
                    if (bitpos == BW'(WORD_W - 1)) begin
                        word_valid_o <= 1'b1;
                        word_o       <= {shreg[WORD_W-2:0], sdata_i};
                        word_idx_o   <= widx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/chain_readout.sv
// Top of the cascaded converter readout controller. Assumes every converter
// runs in host-clocked mode, the first tag input is tied low, and reading
// happens only in the sampling period after BUSY returns high.
module chain_readout
    import chain_readout_pkg::*;
#(
    parameter int N_DEV       = 2,
    parameter int WORD_W      = 16,
    parameter int HALF_CYC    = 3,
    parameter int CONV_CYC    = 4,
    parameter int TIMEOUT_CYC = 64,
    localparam int IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              sdata_i,
    output logic              rc_o,
    output logic              dclk_o,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic              done_o,
    output logic              frame_err_o,
    output logic              timeout_err_o
);
    localparam int SLOT_W = WORD_W + 1;
    localparam int PULSES = N_DEV * SLOT_W;

    rd_state_t state;
    logic      start_ok;
    logic      fall;
    logic      last;

    assign rc_o   = (state != ST_CONV);
    assign done_o = (state == ST_DONE);

    rd_sequencer #(
        .CONV_CYC   (CONV_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .busy_i     (busy_i),
        .burst_end_i(last),
        .state_o    (state),
        .start_ok_o (start_ok),
        .timeout_o  (timeout_err_o)
    );

    rd_clkgen #(
        .HALF_CYC(HALF_CYC),
        .PULSES  (PULSES)
    ) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (state == ST_READ),
        .dclk_o(dclk_o),
        .fall_o(fall),
        .last_o(last)
    );

    rd_deframer #(
        .WORD_W(WORD_W),
        .IDX_W (IDX_W)
    ) u_defr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_ok),
        .fall_i      (fall),
        .sdata_i     (sdata_i),
        .word_valid_o(word_valid_o),
        .word_o      (word_o),
        .word_idx_o  (word_idx_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: rtl/chain_readout_chk.sv
// Property checker for chain_readout, attached by bind below.
module chain_readout_chk #(
    parameter int HALF_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic rc_o,
    input logic dclk_o,
    input logic word_valid_o,
    input logic done_o,
    input logic timeout_err_o
);
    logic [15:0] high_cnt;

    // Length of the current high phase of the data clock
    always_ff @(posedge clk) begin
        if (!rst_n || !dclk_o) high_cnt <= '0;
        else                   high_cnt <= high_cnt + 1'b1;
    end

    // R3: no data clock while a conversion is being commanded
    a_r3_no_clk_in_convert: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_o |-> !dclk_o);
    // R3: rising clock edges only while BUSY is high
    a_r3_rise_when_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> busy_i);
    // R4: every high phase is exactly HALF_CYC cycles
    a_r4_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dclk_o) |-> high_cnt == 16'(HALF_CYC));
    // R5: words are only delivered in the sampling period
    a_r5_valid_when_sampling: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> busy_i && rc_o);
    // R7: a timed-out frame carries no clock
    a_r7_no_clk_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |-> !dclk_o);
    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind chain_readout chain_readout_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .rc_o         (rc_o),
    .dclk_o       (dclk_o),
    .word_valid_o (word_valid_o),
    .done_o       (done_o),
    .timeout_err_o(timeout_err_o)
);

// File: tb/chain_readout_tb.sv
// Bench: behavioural converter chain and BUSY model, per-clock monitor.
module chain_readout_tb;
    localparam int N    = 2;
    localparam int HALF = 3;
    localparam int CONV = 4;
    localparam int TMO  = 64;
    localparam int PULSES = N * 17;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, busy = 1'b1, sdata = 1'b0;
    logic rc, dclk, wvalid, done, ferr, terr;
    logic [15:0] word;
    logic [0:0]  widx;

    int checks = 0, errors = 0;
    bit bitq[$];
    logic [15:0] expw[$];
    int expi[$];
    int hang = 0;
    int pulses, done_cnt, bad_hi, bad_lo, rcl, last_rcl, rc_falls, conv_viol, run;
    logic prev_dclk = 1'b0, prev_rc = 1'b1;

    chain_readout #(.N_DEV(N), .WORD_W(16), .HALF_CYC(HALF), .CONV_CYC(CONV),
                    .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy), .sdata_i(sdata),
        .rc_o(rc), .dclk_o(dclk), .word_valid_o(wvalid), .word_o(word),
        .word_idx_o(widx), .done_o(done), .frame_err_o(ferr), .timeout_err_o(terr));

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Converter chain: each rising data-clock edge presents the next bit
    initial forever begin
        @(posedge dclk);
        #1 sdata = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
    end

    // BUSY: falls shortly after convert, returns after the conversion time
    initial forever begin
        @(negedge rc);
        if (hang != 1) begin
            repeat (2) @(posedge clk);
            #1 busy = 1'b0;
            if (hang == 0) begin
                repeat (20) @(posedge clk);
                #1 busy = 1'b1;
            end
        end
    end

    // Per-clock reference monitor, sampled away from the active edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (dclk != prev_dclk) begin
                if (prev_dclk && run != HALF) bad_hi++;
                if (!prev_dclk && pulses > 0 && run != HALF) bad_lo++;
                if (dclk) pulses++;
                run = 1;
            end else run++;
            if (dclk && (!busy || !rc)) conv_viol++;
            if (!rc) rcl++;
            else if (rcl != 0) begin last_rcl = rcl; rcl = 0; end
            if (!rc && prev_rc) rc_falls++;
            if (done) done_cnt++;
            if (wvalid) begin
                if (expw.size() == 0) check(0, "R5", "unexpected word", word, 0);
                else begin
                    check(word == expw[0], "R5", "word value", word, expw[0]);
                    check(int'(widx) == expi[0], "R5", "word index", widx, expi[0]);
                    void'(expw.pop_front());
                    void'(expi.pop_front());
                end
            end
        end
        prev_dclk = dclk;
        prev_rc   = rc;
    end

    task automatic run_frame(input logic [15:0] w0, input logic [15:0] w1,
                             input bit [1:0] nulls, input int hang_m,
                             input bit mid_start);
        logic [15:0] ws[2];
        ws[0] = w0; ws[1] = w1;
        pulses = 0; done_cnt = 0; bad_hi = 0; bad_lo = 0; rc_falls = 0;
        conv_viol = 0; last_rcl = 0;
        hang = hang_m;
        bitq.delete(); expw.delete(); expi.delete();
        for (int k = 0; k < N; k++) begin
            for (int b = 15; b >= 0; b--) bitq.push_back(ws[k][b]);
            bitq.push_back(nulls[k]);
            if (hang_m == 0) begin expw.push_back(ws[k]); expi.push_back(k); end
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (mid_start) begin
            while (!wvalid) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        check(pulses == (hang_m == 0 ? PULSES : 0), "R4", "pulse count", pulses,
              hang_m == 0 ? PULSES : 0);
        check(bad_hi == 0 && bad_lo == 0, "R4", "phase lengths", bad_hi + bad_lo, 0);
        check(last_rcl == CONV, "R2", "convert pulse length", last_rcl, CONV);
        check(rc_falls == 1, "R9", "convert pulses per frame", rc_falls, 1);
        check(conv_viol == 0, "R3", "clock during conversion", conv_viol, 0);
        check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
        check(expw.size() == 0, "R5", "words missing", expw.size(), 0);
        check(terr == (hang_m != 0), "R7", "timeout flag", terr, hang_m != 0);
        check(ferr == (hang_m == 0 && nulls != 0), "R6", "frame error flag", ferr,
              hang_m == 0 && nulls != 0);
        hang = 0;
        busy = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(rc == 1'b1, "R1", "rc in reset", rc, 1);
        check(dclk == 1'b0 && wvalid == 1'b0 && done == 1'b0, "R1", "strobes in reset",
              {dclk, wvalid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ferr == 1'b0 && terr == 1'b0, "R1", "flags after reset", {ferr, terr}, 0);
        check(rc == 1'b1 && dclk == 1'b0, "R1", "idle after reset", {rc, dclk}, 2);

        run_frame(16'h1234, 16'hABCD, 2'b00, 0, 1'b0);   // R5 mixed values
        run_frame(16'hFFFF, 16'h0000, 2'b00, 0, 1'b0);   // R5 slot boundary
        run_frame(16'h8000, 16'h0001, 2'b00, 0, 1'b0);   // R5 MSB/LSB order
        run_frame(16'h5A5A, 16'hC3C3, 2'b10, 0, 1'b0);   // R6 bad separator
        repeat (20) @(negedge clk);
        check(ferr == 1'b1, "R6", "flag sticky while idle", ferr, 1);
        run_frame(16'h0F0F, 16'hF0F0, 2'b00, 0, 1'b0);   // R6 cleared by start
        run_frame(16'h0000, 16'h0000, 2'b00, 1, 1'b0);   // R7 BUSY never falls
        run_frame(16'h0000, 16'h0000, 2'b00, 2, 1'b0);   // R7 BUSY never returns
        run_frame(16'h7E81, 16'h1818, 2'b00, 0, 1'b1);   // R9 start mid-burst
        check(rc == 1'b1 && dclk == 1'b0, "R9", "idle after ignored start", {rc, dclk}, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WDOG", "run did not finish", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule